// File: doc/BRIEF.md
# Galois Field Log and Antilog Table Generator

This block fills a pair of lookup memories for GF(2^m), with the field degree m chosen at run time from 3 up to a build-time ceiling. The antilog memory maps an exponent i to the field element alpha^i. The log memory maps a field element back to its exponent. A start pulse latches the requested degree. A linear feedback shift register then steps through the powers of the primitive element, one power per clock, using a fixed primitive polynomial for each degree. In every step cycle the block writes one antilog entry and one log entry on two independent synchronous write ports.

After the last power has been written, the block writes a sentinel value (all ones) into the zero slot of the log memory, because zero has no logarithm. It then raises a level done flag, which stays high until the next accepted start. Reading the memories back and doing field arithmetic with them belong to other blocks.

Top module: `gf_table_gen`

## Requirements
- R1: After reset, busy and done are low and neither write enable is asserted.
- R2: A start pulse with a legal degree, taken while idle, begins a walk in the next cycle. For n = 2^m - 1, the block then asserts both write enables and busy for n+1 consecutive cycles, with antilog addresses 0, 1, ..., n in order.
- R3: For exponents i below m, the antilog data is 1 << i. At exponent m it is the primitive polynomial with its x^m term removed. The extra taps beyond the constant term are: m=3,4,6,15: x; m=5,11: x^2; m=7,10: x^3; m=9: x^4; m=8: x^2,x^3,x^4; m=12: x,x^4,x^6; m=13: x,x^3,x^4; m=14: x,x^6,x^10.
- R4: Each element after exponent m is computed from the previous one. If bit m-1 of the previous element is set, that bit is cleared, the value is shifted left by one and XORed with the reduced polynomial. Otherwise the previous element is only shifted left.
- R5: In each walk cycle the log port writes data i mod n at an address equal to the antilog data. The final step (i = n) therefore writes 0 to address 1.
- R6: In the cycle after the last walk step, the log port alone writes all ones to address 0, and the antilog write enable is low.
- R7: done rises in the cycle after the sentinel write, busy falls in the same cycle, and done stays high until the next accepted start, which clears it.
- R8: A start pulse while busy is ignored. The walk in progress continues with its original degree and sequence.
- R9: A start pulse while idle whose degree is below 3 or above the ceiling is ignored. No write occurs, and busy and done keep their values.
- R10: The antilog entries 0..n-1 hold every nonzero element exactly once, the element 1 reappears only at index n, and the log table is the inverse of the antilog table.
- R11: Except for the sentinel data, every address and data value has zeros in all bits at and above bit m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Start request, sampled while idle |
| m_sel | input | 4 | Requested field degree, latched on an accepted start |
| alog_we | output | 1 | Antilog memory write enable |
| alog_addr | output | M_MAX | Antilog write address (exponent) |
| alog_data | output | M_MAX | Antilog write data (field element) |
| log_we | output | 1 | Log memory write enable |
| log_addr | output | M_MAX | Log write address (field element) |
| log_data | output | M_MAX | Log write data (exponent or sentinel) |
| busy | output | 1 | High from the first walk cycle through the sentinel cycle |
| done | output | 1 | High once a table pair is complete, until the next accepted start |

## Verification
The assertions assume that the degree is latched once per walk and that the register only advances while a walk is active. Under those conditions the element can never become zero, the antilog address rises by exactly one per write, and the sentinel follows the last pair directly. The stimulus drives start and m_sel only at falling edges. It mixes legal degrees with illegal ones (0, 1, 2), and it also pulses start in the middle of a walk so that the ignore rules are exercised rather than assumed. Every degree from 3 to 15 is walked in full. Degrees up to 11 are additionally captured into bench memories so that the permutation and inverse properties can be checked.

// File: rtl/gf_tab_pkg.sv
package gf_tab_pkg;

  localparam int GF_M_LIMIT = 15;
  localparam int GF_MW      = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_SENT = 2'd2
  } gf_state_e;

  // Reduced primitive polynomial (x^m term dropped) for each degree.
  function automatic logic [GF_M_LIMIT-1:0] prim_taps(input logic [GF_MW-1:0] m);
    logic [GF_M_LIMIT-1:0] t;
    case (m)
      4'd3:    t = 15'h0003;
      4'd4:    t = 15'h0003;
      4'd5:    t = 15'h0005;
      4'd6:    t = 15'h0003;
      4'd7:    t = 15'h0009;
      4'd8:    t = 15'h001D;
      4'd9:    t = 15'h0011;
      4'd10:   t = 15'h0009;
      4'd11:   t = 15'h0005;
      4'd12:   t = 15'h0053;
      4'd13:   t = 15'h001B;
      4'd14:   t = 15'h0443;
      4'd15:   t = 15'h0003;
      default: t = 15'h0003;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/gf_tab_ctrl.sv
module gf_tab_ctrl
  import gf_tab_pkg::*;
#(
  parameter int M_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GF_MW-1:0] m_req,
  output logic             walk,
  output logic             sent,
  output logic             busy,
  output logic             done,
  output logic             load,
  output logic             adv,
  output logic [M_MAX-1:0] idx,
  output logic [GF_MW-1:0] m_len,
  output logic [M_MAX-1:0] n_val
);

  gf_state_e        state_q, state_d;
  logic [M_MAX-1:0] idx_d;
  logic             idx_en;
  logic [GF_MW-1:0] m_d;
  logic             m_en;
  logic             done_d;
  logic             done_en;
  logic             m_ok;
  logic             accept;
  logic             last;

  assign n_val  = (M_MAX'(1) << m_len) - M_MAX'(1);
  assign m_ok   = (m_req >= GF_MW'(3)) && (m_req <= GF_MW'(M_MAX));
  assign accept = (state_q == ST_IDLE) && start && m_ok;
  assign walk   = (state_q == ST_WALK);
  assign sent   = (state_q == ST_SENT);
  assign last   = walk && (idx == n_val);
  assign busy   = walk || sent;
  assign load   = accept;
  assign adv    = walk;

  always_comb begin
    state_d = state_q;
    idx_d   = idx;
    idx_en  = 1'b0;
    m_d     = m_len;
    m_en    = 1'b0;
    done_d  = done;
    done_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_WALK;
          idx_d   = '0;
          idx_en  = 1'b1;
          m_d     = m_req;
          m_en    = 1'b1;
          done_d  = 1'b0;
          done_en = 1'b1;
        end
      end
      ST_WALK: begin
        idx_d  = idx + M_MAX'(1);
        idx_en = 1'b1;
        if (last) state_d = ST_SENT;
      end
      ST_SENT: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        done_en = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx     <= '0;
      m_len   <= GF_MW'(3);
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idx_en)  idx   <= idx_d;
      if (m_en)    m_len <= m_d;
      if (done_en) done  <= done_d;
    end
  end

  // R2
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk && !last) |=> (walk && idx == $past(idx) + M_MAX'(1)));

  // R7
  done_after_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state_q) == ST_SENT));

  // R8
  m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(m_len));

  // R9
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && start && (m_req < GF_MW'(3))) |=> (!busy && $stable(done)));

endmodule

// File: rtl/gf_tab_lfsr.sv
module gf_tab_lfsr
  import gf_tab_pkg::*;
#(
  parameter int M_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [GF_MW-1:0] m_len,
  input  logic [M_MAX-1:0] taps,
  output logic [M_MAX-1:0] elem
);

  logic [M_MAX-1:0] step;
  logic [M_MAX-1:0] elem_d;
  logic             elem_en;
  logic             fb;

  assign fb = elem[m_len - GF_MW'(1)];

  for (genvar b = 0; b < M_MAX; b++) begin : g_bit
    if (b == 0) begin : g_lsb
      assign step[b] = fb & taps[b];
    end else begin : g_up
      assign step[b] = (elem[b-1] & (b < int'(m_len))) ^ (fb & taps[b]);
    end
  end

  always_comb begin
    elem_d  = elem;
    elem_en = 1'b0;
    if (load) begin
      elem_d  = M_MAX'(1);
      elem_en = 1'b1;
    end else if (adv) begin
      elem_d  = step;
      elem_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elem <= M_MAX'(1);
    else if (elem_en) elem <= elem_d;
  end

  // R10
  elem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (elem != '0));

  // R11
  elem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ((elem >> m_len) == '0));

endmodule

// File: rtl/gf_tab_wport.sv
module gf_tab_wport #(
  parameter int M_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk,
  input  logic             sent,
  input  logic [M_MAX-1:0] idx,
  input  logic [M_MAX-1:0] elem,
  input  logic [M_MAX-1:0] n_val,
  output logic             alog_we,
  output logic [M_MAX-1:0] alog_addr,
  output logic [M_MAX-1:0] alog_data,
  output logic             log_we,
  output logic [M_MAX-1:0] log_addr,
  output logic [M_MAX-1:0] log_data
);

  always_comb begin
    alog_we   = 1'b0;
    alog_addr = '0;
    alog_data = '0;
    log_we    = 1'b0;
    log_addr  = '0;
    log_data  = '0;
    if (walk) begin
      alog_we   = 1'b1;
      alog_addr = idx;
      alog_data = elem;
      log_we    = 1'b1;
      log_addr  = elem;
      log_data  = (idx == n_val) ? '0 : idx;
    end else if (sent) begin
      log_we    = 1'b1;
      log_addr  = '0;
      log_data  = '1;
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alog_we && $past(alog_we)) |-> (alog_addr == $past(alog_addr) + M_MAX'(1)));

  // R6
  sentinel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_we && !alog_we) |-> ($past(alog_we) && $past(log_data) == '0));

endmodule

// File: rtl/gf_table_gen.sv
module gf_table_gen
  import gf_tab_pkg::*;
#(
  parameter int M_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       m_sel,
  output logic             alog_we,
  output logic [M_MAX-1:0] alog_addr,
  output logic [M_MAX-1:0] alog_data,
  output logic             log_we,
  output logic [M_MAX-1:0] log_addr,
  output logic [M_MAX-1:0] log_data,
  output logic             busy,
  output logic             done
);

  logic             walk, sent, load, adv;
  logic [M_MAX-1:0] idx, elem, n_val, taps;
  logic [GF_MW-1:0] m_len;
  logic [GF_M_LIMIT-1:0] taps_full;

  assign taps_full = prim_taps(m_len);
  assign taps      = taps_full[M_MAX-1:0];

  gf_tab_ctrl #(.M_MAX(M_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .m_req(m_sel),
    .walk(walk), .sent(sent), .busy(busy), .done(done),
    .load(load), .adv(adv), .idx(idx), .m_len(m_len), .n_val(n_val)
  );

  gf_tab_lfsr #(.M_MAX(M_MAX)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .m_len(m_len), .taps(taps), .elem(elem)
  );

  gf_tab_wport #(.M_MAX(M_MAX)) u_wport (
    .clk(clk), .rst_n(rst_n), .walk(walk), .sent(sent),
    .idx(idx), .elem(elem), .n_val(n_val),
    .alog_we(alog_we), .alog_addr(alog_addr), .alog_data(alog_data),
    .log_we(log_we), .log_addr(log_addr), .log_data(log_data)
  );

  // R3
  wrap_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alog_we && alog_addr == n_val) |-> (alog_data == M_MAX'(1)));

endmodule

// File: tb/gf_table_gen_tb.sv
module gf_table_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MW         = 15;
  localparam int STORE_M    = 11;
  localparam int STORE_N    = 1 << STORE_M;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    m_sel = 4'd0;
  logic          alog_we, log_we, busy, done;
  logic [MW-1:0] alog_addr, alog_data, log_addr, log_data;

  int tests = 0;
  int fails = 0;
  logic [MW-1:0] amem [0:STORE_N-1];
  logic [MW-1:0] lmem [0:STORE_N-1];

  gf_table_gen #(.M_MAX(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .m_sel(m_sel),
    .alog_we(alog_we), .alog_addr(alog_addr), .alog_data(alog_data),
    .log_we(log_we), .log_addr(log_addr), .log_data(log_data),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_taps(int m);
    case (m)
      3, 4, 6, 15: return 32'h3;
      5, 11:       return 32'h5;
      7, 10:       return 32'h9;
      8:           return 32'h1D;
      9:           return 32'h11;
      12:          return 32'h53;
      13:          return 32'h1B;
      14:          return 32'h443;
      default:     return 0;
    endcase
  endfunction

  function automatic int ref_next(int prev, int m);
    int mask = (1 << m) - 1;
    if (((prev >> (m - 1)) & 1) != 0)
      return (((prev & ~(1 << (m - 1))) << 1) ^ ref_taps(m)) & mask;
    return (prev << 1) & mask;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_walk(input int m, input int inj_at, input int inj_m);
    int n = (1 << m) - 1;
    int ex = 1;
    int early_one = 0;
    @(negedge clk);
    start = 1'b1;
    m_sel = 4'(m);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= n; i++) begin
      if (i > 0) @(negedge clk);
      check(alog_we && busy, "R2", "walk enables", {alog_we, busy}, 3);
      check(int'(alog_addr) == i, "R2", "antilog addr", alog_addr, i);
      check(int'(alog_data) == ex, (i <= m) ? "R3" : "R4", "antilog data", alog_data, ex);
      check(log_we && int'(log_addr) == ex, "R5", "log addr", log_addr, ex);
      check(int'(log_data) == (i % n), "R5", "log data", log_data, i % n);
      check((alog_addr >> m) == 0 && (log_data >> m) == 0, "R11", "upper bits",
            int'(alog_addr >> m), 0);
      if (m <= STORE_M) begin
        amem[i] = alog_data;
        lmem[log_addr] = log_data;
      end
      if (i > 0 && i < n && alog_data == 1) early_one++;
      if (i == inj_at) begin start = 1'b1; m_sel = 4'(inj_m); end
      if (i == inj_at + 1) start = 1'b0;
      ex = ref_next(ex, m);
    end
    start = 1'b0;
    @(negedge clk);
    check(!alog_we && log_we, "R6", "sentinel enables", {alog_we, log_we}, 1);
    check(log_addr == 0 && log_data == '1, "R6", "sentinel value", log_data, 32'h7FFF);
    if (m <= STORE_M) lmem[log_addr] = log_data;
    @(negedge clk);
    check(done && !busy && !alog_we && !log_we, "R7", "done state",
          {done, busy, alog_we, log_we}, 8);
    check(early_one == 0, "R10", "element 1 before index n", early_one, 0);
    if (m <= STORE_M) begin
      int dup = 0;
      int bad_inv = 0;
      int cnt [0:STORE_N-1];
      for (int v = 0; v < STORE_N; v++) cnt[v] = 0;
      for (int i = 0; i < n; i++) cnt[amem[i]]++;
      for (int v = 1; v <= n; v++) if (cnt[v] != 1) dup++;
      check(dup == 0 && cnt[0] == 0, "R10", "antilog permutation", dup, 0);
      for (int v = 1; v <= n; v++) if (int'(amem[lmem[v]]) != v) bad_inv++;
      for (int i = 0; i < n; i++) if (int'(lmem[amem[i]]) != i) bad_inv++;
      check(bad_inv == 0, "R10", "log/antilog inverse", bad_inv, 0);
      check(lmem[0] == '1, "R6", "log zero sentinel", lmem[0], 32'h7FFF);
    end
  endtask

  task automatic bad_start(input int m);
    logic was_done;
    @(negedge clk);
    was_done = done;
    start = 1'b1;
    m_sel = 4'(m);
    @(negedge clk);
    start = 1'b0;
    check(!busy && !alog_we && !log_we && done == was_done, "R9",
          "illegal degree ignored", {busy, alog_we, log_we}, 0);
    @(negedge clk);
    check(!busy && !alog_we && !log_we && done == was_done, "R9",
          "illegal degree still idle", {busy, done}, {1'b0, was_done});
  endtask

  initial begin : main
    int unsigned seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(!busy && !done && !alog_we && !log_we, "R1", "reset outputs",
          {busy, done, alog_we, log_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !alog_we && !log_we, "R1", "idle after reset",
          {busy, done, alog_we, log_we}, 0);
    bad_start(2);
    for (int m = 3; m <= 15; m++) run_walk(m, (m == 4) ? 3 : -1, 9);
    bad_start(0);
    bad_start(1);
    for (int k = 0; k < 8; k++) begin
      int m = 3 + int'($urandom_range(0, 8));
      int inj = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 5)) : -1;
      run_walk(m, inj, 3 + int'($urandom_range(0, 12)));
      if ($urandom_range(0, 1) == 1) bad_start(int'($urandom_range(0, 2)));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule